// File: doc/BRIEF.md
# Two-Level Priority Message Bus Arbiter

This block is the central arbiter for a shared 32-bit synchronous message bus clocked at 33 MHz. Several requesters use the bus. Each one sends either command messages, which are served at low priority, or frame-data messages, which are served at high priority. Each requester has its own active-low request line and a class bit that marks a pending data message. A shared, wired, active-low high-priority line tells the arbiter that data traffic is waiting. An active-low overload input tells it that all data-forwarding bandwidth is committed. The arbiter returns one active-low grant per requester.

Once a grant is issued, the block watches the framing signals on the bus to decide when the bus is free again:
- the active-low message envelope, which spans the whole transfer;
- the active-high initiator-ready signal, which marks wait states;
- the active-low end-of-frame signal;
- the active-low target abort.

The grant is held until the envelope closes or a target aborts. The bus then stays idle for one cycle before the next grant. The block also gives three framing strobes to the rest of the chip: message start, word valid and frame end. Header contents and frame data are not handled here.

Top module: `msgbus_arbiter`

## Requirements
- R1: While rst_n is low, every bit of gnt_n is high, whatever the request inputs are.
- R2: At most one bit of gnt_n is low in any cycle.
- R3: When the bus is free and a requester is eligible, the grant is registered at the next rising edge. Requester i is always bit i of req_n, data_msg and gnt_n.
- R4: A requester with data_msg=1 is eligible only while hp_n is low and ovld_n is high. When such a requester exists, the grant goes to a data requester, even if command requesters are also pending.
- R5: While ovld_n is low, no requester with data_msg=1 is granted. Command requesters (data_msg=0) are still granted.
- R6: Each priority level has its own round-robin pointer. A new grant at a level goes to the first requesting index above the last index granted at that level, wrapping from N-1 to 0. After reset, both pointers start as if index N-1 had just been granted.
- R7: An issued grant stays unchanged while the envelope has not yet opened and while it is open. New requests, hp_n and ovld_n do not change it.
- R8: A grant whose envelope has opened is withdrawn at the first rising edge at which env_n is sampled high again.
- R9: tabt_n sampled low while a grant is held withdraws the grant at that edge.
- R10: After a grant is withdrawn, gnt_n is all-high for at least one cycle before any new grant, even when requests are still pending.
- R11: msg_start is high in the cycle in which env_n is low after having been high at the previous rising edge.
- R12: word_strobe is high exactly when env_n is low and irdy is high. When irdy is low (a wait state), word_strobe is low.
- R13: frame_end is high exactly when word_strobe is high and eof_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N | Per-requester bus request, active low |
| data_msg | input | N | Per-requester class: 1 = pending data message, 0 = command message |
| hp_n | input | 1 | Shared wired high-priority request, active low |
| ovld_n | input | 1 | Data bandwidth overload, active low |
| env_n | input | 1 | Message envelope, active low |
| irdy | input | 1 | Initiator ready, active high; low marks a wait state |
| eof_n | input | 1 | End of frame, active low |
| tabt_n | input | 1 | Target abort, active low |
| gnt_n | output | N | Per-requester bus grant, active low |
| msg_start | output | 1 | Pulse on the leading edge of the envelope |
| word_strobe | output | 1 | Qualified data word on the bus |
| frame_end | output | 1 | Qualified word carrying end of frame |

## Verification
The hardest state to reach from the ports is a pending high-priority request that arrives while a command message already owns the bus. The arbiter must ignore it until the envelope closes and then honour the idle gap. The bench gets there by first granting a command requester, then raising data requests and hp_n before the envelope opens. It checks that the grant holds, and only afterwards runs the envelope to its end. Reaching the round-robin wrap at each level needs a known pointer history. The table of vectors is therefore ordered so that the pointer positions build up deliberately, including a level that is skipped under overload.

// File: rtl/msgarb_pkg.sv
package msgarb_pkg;
  typedef enum logic {
    ST_FREE = 1'b0,
    ST_HELD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/msgarb_rr.sv
module msgarb_rr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cand,
  input  logic         take,
  output logic [N-1:0] pick,
  output logic         any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q;

  // First set bit of r strictly after index last, cyclic.
  function automatic logic [N-1:0] next_onehot(input logic [N-1:0] r,
                                               input logic [IW-1:0] last);
    logic [N-1:0] g;
    int idx;
    g = '0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (g == '0 && r[idx]) g[idx] = 1'b1;
    end
    return g;
  endfunction

  function automatic logic [IW-1:0] to_index(input logic [N-1:0] oh);
    logic [IW-1:0] v;
    v = '0;
    for (int k = 0; k < N; k++) begin
      if (oh[k]) v = IW'(k);
    end
    return v;
  endfunction

  assign pick = next_onehot(cand, last_q);
  assign any  = |cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
    end else if (take && any) begin
      last_q <= to_index(pick);
    end
  end
endmodule

// File: rtl/msgarb_track.sv
module msgarb_track (
  input  logic clk,
  input  logic rst_n,
  input  logic env_n,
  input  logic irdy,
  input  logic eof_n,
  output logic msg_start,
  output logic word_strobe,
  output logic frame_end
);
  logic env_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) env_prev_q <= 1'b1;
    else        env_prev_q <= env_n;
  end

  assign msg_start   = env_prev_q & ~env_n;
  assign word_strobe = ~env_n & irdy;
  assign frame_end   = word_strobe & ~eof_n;
endmodule

// File: rtl/msgbus_arbiter.sv
module msgbus_arbiter
  import msgarb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  input  logic [N-1:0] data_msg,
  input  logic         hp_n,
  input  logic         ovld_n,
  input  logic         env_n,
  input  logic         irdy,
  input  logic         eof_n,
  input  logic         tabt_n,
  output logic [N-1:0] gnt_n,
  output logic         msg_start,
  output logic         word_strobe,
  output logic         frame_end
);
  arb_state_e   state_q;
  logic [N-1:0] gnt_q;
  logic         seen_env_q;

  // Named internal events
  logic [N-1:0] hi_cand, lo_cand, hi_pick, lo_pick, winner;
  logic         hi_any, lo_any, use_hi, take_hi, take_lo;
  logic         bus_free, release_evt, grant_evt;

  assign hi_cand = (!hp_n && ovld_n) ? (~req_n & data_msg) : '0;
  assign lo_cand = ~req_n & ~data_msg;

  msgarb_rr #(.N(N)) u_rr_hi (
    .clk(clk), .rst_n(rst_n), .cand(hi_cand), .take(take_hi),
    .pick(hi_pick), .any(hi_any)
  );

  msgarb_rr #(.N(N)) u_rr_lo (
    .clk(clk), .rst_n(rst_n), .cand(lo_cand), .take(take_lo),
    .pick(lo_pick), .any(lo_any)
  );

  assign bus_free    = (state_q == ST_FREE);
  assign use_hi      = hi_any;
  assign winner      = use_hi ? hi_pick : lo_pick;
  assign take_hi     = bus_free & use_hi;
  assign take_lo     = bus_free & ~use_hi & lo_any;
  assign grant_evt   = take_hi | take_lo;
  assign release_evt = (state_q == ST_HELD) & ((seen_env_q & env_n) | ~tabt_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_FREE;
      gnt_q      <= '0;
      seen_env_q <= 1'b0;
    end else if (state_q == ST_HELD) begin
      if (release_evt) begin
        state_q    <= ST_FREE;
        gnt_q      <= '0;
        seen_env_q <= 1'b0;
      end else if (!env_n) begin
        seen_env_q <= 1'b1;
      end
    end else if (grant_evt) begin
      state_q    <= ST_HELD;
      gnt_q      <= winner;
      seen_env_q <= 1'b0;
    end
  end

  assign gnt_n = ~gnt_q;

  msgarb_track u_track (
    .clk(clk), .rst_n(rst_n), .env_n(env_n), .irdy(irdy), .eof_n(eof_n),
    .msg_start(msg_start), .word_strobe(word_strobe), .frame_end(frame_end)
  );
endmodule

// File: rtl/msgarb_checker.sv
module msgarb_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_n,
  input logic [N-1:0] data_msg,
  input logic         hp_n,
  input logic         ovld_n,
  input logic         env_n,
  input logic         tabt_n,
  input logic [N-1:0] gnt_n
);
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  a_r10_gap_between_owners: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n != $past(gnt_n)) |-> ((&gnt_n) || (&$past(gnt_n))));

  a_r9_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n) && !tabt_n) |=> (&gnt_n));

  a_r8_envelope_end_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n) && !(&$past(gnt_n)) && $rose(env_n)) |=> (&gnt_n));

  a_r5_overload_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovld_n && (&gnt_n)) |=> ((~gnt_n & $past(data_msg)) == '0));

  a_r4_data_preempts_command: assert property (@(posedge clk) disable iff (!rst_n)
    ((&gnt_n) && !hp_n && ovld_n && ((~req_n & data_msg) != '0))
      |=> ((~gnt_n & $past(data_msg)) != '0));
endmodule

bind msgbus_arbiter msgarb_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .data_msg(data_msg), .hp_n(hp_n),
  .ovld_n(ovld_n), .env_n(env_n), .tabt_n(tabt_n), .gnt_n(gnt_n)
);

// File: tb/test_msgbus_arbiter.sv
`timescale 1ns/1ps
module test_msgbus_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_n, data_msg, gnt_n;
  logic         hp_n, ovld_n, env_n, irdy, eof_n, tabt_n;
  logic         msg_start, word_strobe, frame_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msgbus_arbiter #(.N(N)) i_msgbus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .data_msg(data_msg), .hp_n(hp_n),
    .ovld_n(ovld_n), .env_n(env_n), .irdy(irdy), .eof_n(eof_n), .tabt_n(tabt_n),
    .gnt_n(gnt_n), .msg_start(msg_start), .word_strobe(word_strobe),
    .frame_end(frame_end)
  );

  // {active requests, data class, hp_n, ovld_n, expected active grant}
  localparam logic [13:0] VEC [0:9] = '{
    {4'b0011, 4'b0000, 1'b1, 1'b1, 4'b0001},
    {4'b0011, 4'b0000, 1'b1, 1'b1, 4'b0010},
    {4'b0011, 4'b0000, 1'b1, 1'b1, 4'b0001},
    {4'b1111, 4'b1100, 1'b0, 1'b1, 4'b0100},
    {4'b1111, 4'b1100, 1'b0, 1'b1, 4'b1000},
    {4'b1111, 4'b1100, 1'b0, 1'b0, 4'b0010},
    {4'b0100, 4'b0100, 1'b0, 1'b0, 4'b0000},
    {4'b0101, 4'b0100, 1'b1, 1'b1, 4'b0001},
    {4'b1010, 4'b0000, 1'b1, 1'b1, 4'b0010},
    {4'b1010, 4'b0000, 1'b1, 1'b1, 4'b1000}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0:       return "R3 R2 first command grant";
      1, 2:    return "R6 command round-robin wrap";
      3:       return "R4 data over command";
      4:       return "R6 data round-robin";
      5:       return "R5 overload serves command";
      6:       return "R5 overload blocks data";
      7:       return "R4 data needs shared line";
      default: return "R6 sparse command round-robin";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Open the envelope for len cycles, close it, and check release (R8).
  task automatic run_message(input int len, input string tag);
    @(negedge clk);
    env_n = 1'b0;
    irdy  = 1'b1;
    repeat (len) @(negedge clk);
    env_n = 1'b1;
    @(posedge clk);
    #1;
    chk(&gnt_n, tag, 32'(gnt_n), 32'hF);
  endtask

  initial begin
    rst_n = 1'b0; req_n = '0; data_msg = '0; hp_n = 1'b1; ovld_n = 1'b1;
    env_n = 1'b1; irdy = 1'b0; eof_n = 1'b1; tabt_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(gnt_n == 4'hF, "R1 no grant in reset", 32'(gnt_n), 32'hF);
    @(negedge clk);
    req_n = '1;
    rst_n = 1'b1;
    @(negedge clk);

    // Table of vectors
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      req_n    = ~VEC[i][13:10];
      data_msg = VEC[i][9:6];
      hp_n     = VEC[i][5];
      ovld_n   = VEC[i][4];
      @(posedge clk);
      #1;
      chk(gnt_n == ~VEC[i][3:0], vec_tag(i), 32'(~gnt_n), 32'(VEC[i][3:0]));
      @(negedge clk);
      req_n = '1; hp_n = 1'b1; ovld_n = 1'b1;
      if (VEC[i][3:0] != 4'b0000) run_message(2, "R8 release after envelope");
      @(negedge clk);
    end

    // R7: grant held before and during envelope despite new requests
    @(negedge clk);
    req_n = ~4'b0100; data_msg = '0;
    @(posedge clk);
    #1;
    chk(gnt_n == ~4'b0100, "R7 command grant issued", 32'(~gnt_n), 32'h4);
    @(negedge clk);
    req_n = ~4'b1011; data_msg = 4'b1000; hp_n = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      #1;
      chk(gnt_n == ~4'b0100, "R7 grant held under pending data", 32'(~gnt_n), 32'h4);
    end
    @(negedge clk);
    req_n = '1; hp_n = 1'b1; data_msg = '0;
    run_message(2, "R8 release after held grant");
    @(negedge clk);

    // R9: target abort
    @(negedge clk);
    req_n = ~4'b0001;
    @(posedge clk);
    #1;
    chk(gnt_n == ~4'b0001, "R9 grant before abort", 32'(~gnt_n), 32'h1);
    @(negedge clk);
    req_n = '1; env_n = 1'b0; irdy = 1'b1;
    @(negedge clk);
    tabt_n = 1'b0;
    @(posedge clk);
    #1;
    chk(gnt_n == 4'hF, "R9 abort withdraws grant", 32'(gnt_n), 32'hF);
    @(negedge clk);
    tabt_n = 1'b1; env_n = 1'b1;
    @(negedge clk);

    // R10: idle gap with requests held continuously
    @(negedge clk);
    req_n = ~4'b0011;
    @(posedge clk);
    #1;
    chk(gnt_n == ~4'b0010, "R10 first owner", 32'(~gnt_n), 32'h2);
    @(negedge clk);
    env_n = 1'b0;
    @(negedge clk);
    env_n = 1'b1;
    @(posedge clk);
    #1;
    chk(gnt_n == 4'hF, "R10 idle cycle after release", 32'(gnt_n), 32'hF);
    @(posedge clk);
    #1;
    chk(gnt_n == ~4'b0001, "R10 next owner after gap", 32'(~gnt_n), 32'h1);
    @(negedge clk);
    req_n = '1;
    run_message(1, "R8 release after gap owner");
    @(negedge clk);

    // R11-R13: framing strobes
    @(negedge clk);
    env_n = 1'b0; irdy = 1'b0; eof_n = 1'b1;
    #1;
    chk(msg_start == 1'b1, "R11 start on leading edge", 32'(msg_start), 32'h1);
    chk(word_strobe == 1'b0, "R12 wait state suppresses word", 32'(word_strobe), 32'h0);
    @(posedge clk);
    #1;
    chk(msg_start == 1'b0, "R11 start is one cycle", 32'(msg_start), 32'h0);
    @(negedge clk);
    irdy = 1'b1;
    #1;
    chk(word_strobe == 1'b1, "R12 word with initiator ready", 32'(word_strobe), 32'h1);
    @(negedge clk);
    irdy = 1'b0; eof_n = 1'b0;
    #1;
    chk(frame_end == 1'b0, "R13 no frame end in wait state", 32'(frame_end), 32'h0);
    @(negedge clk);
    irdy = 1'b1;
    #1;
    chk(frame_end == 1'b1, "R13 frame end on ready word", 32'(frame_end), 32'h1);
    @(negedge clk);
    env_n = 1'b1; eof_n = 1'b1; irdy = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule